// File: doc/BRIEF.md
# Two-Stage Periodic Interrupt Timer

This block generates periodic time-outs from two cascaded down-counter stages. A small set of shared prescaler stages divides the module clock. Each is an 8-bit reloadable down-counter that emits a one-cycle tick when it underflows. Every channel owns a 16-bit reloadable down-counter. That counter decrements on the ticks of the prescaler its select field chooses. It raises a sticky time-out flag when it underflows.

Software programs the block through a flat register interface with a single write strobe and a combinational read port. The registers are a global run bit, per-channel enables, the prescaler selects, the load values, per-channel interrupt enables and write-one-to-clear flags. A channel loaded with M behind a prescaler loaded with N fires every (N+1)·(M+1) clock cycles. Each channel has an interrupt line, which is its flag gated by its interrupt enable.

Top module: `cascade_timer`

## Requirements
- R1: After reset every register reads zero, every flag is clear and every interrupt output is low.
- R2: With its channel load at 0, a channel times out every N+1 cycles, where N is the load of its prescaler.
- R3: Suppose the run bit is set by the write at clock edge E, with prescaler load N and channel load M already programmed. The channel's flag is first seen set right after edge E+(N+1)·(M+1).
- R4: The select field of channel c is bit c of the select register (address 2). A 0 makes the channel count ticks of prescaler 0, and a 1 makes it count ticks of prescaler 1.
- R5: A channel whose bit in the enable register (address 1) is clear never times out. When that bit is set, the channel restarts from its current load value.
- R6: Only bit 7 of the control register (address 0) is the run bit. Writing other bits neither starts the timer nor reads back. While the run bit is clear, no flag is set.
- R7: Interrupt output c equals flag c ANDed with bit c of the interrupt-enable register (address 3).
- R8: Writing the flag register (address 4) clears each flag whose data bit is 1 and leaves the flags written with 0 unchanged. A read-OR-write-back therefore clears every flag that was set.
- R9: When a flag-clear write and a new time-out of the same channel fall in the same cycle, the flag stays set.
- R10: The load registers read back what was written. Prescaler p is at address 8+p, 8 bits wide. Channel c is at address 16+c, 16 bits wide. The enable, select and interrupt-enable registers keep only their low four bits.
- R11: On underflow a counter reloads in the same cycle, so the second time-out follows the first by exactly (N+1)·(M+1) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register at bus_addr |
| bus_addr | input | 5 | Register address for both write and read |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq | output | NUM_CH (4) | Per-channel interrupt lines |

## Verification
The bench builds the block with its default parameters: four channels, two prescalers, 8-bit prescaler loads and 16-bit channel loads. Loads are kept small so that every period is a few dozen cycles at most. This makes it possible to sweep a grid of prescaler and channel loads across every channel and both prescaler selections. For each point the bench checks the first and second time-out cycles against (N+1)·(M+1). A period of one cycle lands a flag clear on the next time-out and so exercises the clear-versus-set race. A concurrent run with mixed selects shows that the mux routes the right tick to each channel.

// File: rtl/ct_pkg.sv
package ct_pkg;

  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 16;
  localparam int RUN_BIT = 7;

  localparam logic [ADDR_W-1:0] A_CTRL  = 5'd0;
  localparam logic [ADDR_W-1:0] A_CHEN  = 5'd1;
  localparam logic [ADDR_W-1:0] A_SEL   = 5'd2;
  localparam logic [ADDR_W-1:0] A_INTEN = 5'd3;
  localparam logic [ADDR_W-1:0] A_FLAG  = 5'd4;

  localparam int PSLD_BASE = 8;
  localparam int CHLD_BASE = 16;

  function automatic int sel_width(input int n_src);
    return (n_src <= 1) ? 1 : $clog2(n_src);
  endfunction

endpackage

// File: rtl/ct_prescaler.sv
module ct_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] load,
  output logic         tick
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    tick  = 1'b0;
    if (!run) begin
      cnt_d = load;
    end else if (cnt_q == '0) begin
      tick  = 1'b1;
      cnt_d = load;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
    cnt_en = (cnt_d != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/ct_channel.sv
module ct_channel #(
  parameter int W   = 16,
  parameter int NPS = 2,
  parameter int SW  = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [SW-1:0]  sel,
  input  logic [NPS-1:0] ticks,
  input  logic [W-1:0]   load,
  output logic           timeout
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;
  logic         tick_sel;

  always_comb begin
    tick_sel = ticks[0];
    for (int p = 1; p < NPS; p++) begin
      if (sel == SW'(p)) tick_sel = ticks[p];
    end
  end

  always_comb begin
    cnt_d   = cnt_q;
    timeout = 1'b0;
    if (!run) begin
      cnt_d = load;
    end else if (tick_sel) begin
      if (cnt_q == '0) begin
        timeout = 1'b1;
        cnt_d   = load;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    cnt_en = (cnt_d != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/ct_regs.sv
module ct_regs
  import ct_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int NUM_PS = 2,
  parameter int PS_W   = 8,
  parameter int CNT_W  = 16,
  parameter int SW     = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata,
  input  logic [NUM_CH-1:0]        timeout,
  output logic                     run,
  output logic [NUM_CH-1:0]        ch_en,
  output logic [NUM_CH*SW-1:0]     ch_sel,
  output logic [NUM_CH-1:0]        int_en,
  output logic [NUM_CH-1:0]        flag,
  output logic [NUM_PS*PS_W-1:0]   ps_load,
  output logic [NUM_CH*CNT_W-1:0]  ch_load
);

  localparam int SEL_BITS = NUM_CH * SW;

  logic                    run_q,   run_d;
  logic [NUM_CH-1:0]       chen_q,  chen_d;
  logic [SEL_BITS-1:0]     sel_q,   sel_d;
  logic [NUM_CH-1:0]       inten_q, inten_d;
  logic [NUM_CH-1:0]       flag_q,  flag_d;
  logic [NUM_PS*PS_W-1:0]  psld_q,  psld_d;
  logic [NUM_CH*CNT_W-1:0] chld_q,  chld_d;
  logic                    cfg_en;
  logic                    flag_en;
  logic                    flag_wr;
  logic [NUM_CH-1:0]       clr_mask;

  // configuration next state
  always_comb begin
    run_d   = run_q;
    chen_d  = chen_q;
    sel_d   = sel_q;
    inten_d = inten_q;
    psld_d  = psld_q;
    chld_d  = chld_q;
    if (wr) begin
      case (addr)
        A_CTRL:  run_d   = wdata[RUN_BIT];
        A_CHEN:  chen_d  = wdata[NUM_CH-1:0];
        A_SEL:   sel_d   = wdata[SEL_BITS-1:0];
        A_INTEN: inten_d = wdata[NUM_CH-1:0];
        default: ;
      endcase
      for (int p = 0; p < NUM_PS; p++) begin
        if (addr == ADDR_W'(PSLD_BASE + p)) psld_d[p*PS_W +: PS_W] = wdata[PS_W-1:0];
      end
      for (int c = 0; c < NUM_CH; c++) begin
        if (addr == ADDR_W'(CHLD_BASE + c)) chld_d[c*CNT_W +: CNT_W] = wdata[CNT_W-1:0];
      end
    end
    cfg_en = wr;
  end

  // flag next state: a fresh time-out has priority over a clear
  always_comb begin
    flag_wr  = wr && (addr == A_FLAG);
    clr_mask = flag_wr ? wdata[NUM_CH-1:0] : '0;
    flag_d   = (flag_q & ~clr_mask) | timeout;
    flag_en  = flag_wr || (|timeout);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      chen_q  <= '0;
      sel_q   <= '0;
      inten_q <= '0;
      psld_q  <= '0;
      chld_q  <= '0;
    end else if (cfg_en) begin
      run_q   <= run_d;
      chen_q  <= chen_d;
      sel_q   <= sel_d;
      inten_q <= inten_d;
      psld_q  <= psld_d;
      chld_q  <= chld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  // read port
  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata[RUN_BIT]        = run_q;
      A_CHEN:  rdata[NUM_CH-1:0]     = chen_q;
      A_SEL:   rdata[SEL_BITS-1:0]   = sel_q;
      A_INTEN: rdata[NUM_CH-1:0]     = inten_q;
      A_FLAG:  rdata[NUM_CH-1:0]     = flag_q;
      default: ;
    endcase
    for (int p = 0; p < NUM_PS; p++) begin
      if (addr == ADDR_W'(PSLD_BASE + p)) rdata[PS_W-1:0] = psld_q[p*PS_W +: PS_W];
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == ADDR_W'(CHLD_BASE + c)) rdata[CNT_W-1:0] = chld_q[c*CNT_W +: CNT_W];
    end
  end

  assign run     = run_q;
  assign ch_en   = chen_q;
  assign ch_sel  = sel_q;
  assign int_en  = inten_q;
  assign flag    = flag_q;
  assign ps_load = psld_q;
  assign ch_load = chld_q;

endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
  import ct_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int NUM_PS = 2,
  parameter int PS_W   = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [4:0]        bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq
);

  localparam int SEL_W = sel_width(NUM_PS);

  logic                     run;
  logic [NUM_CH-1:0]        ch_en;
  logic [NUM_CH*SEL_W-1:0]  ch_sel;
  logic [NUM_CH-1:0]        int_en;
  logic [NUM_CH-1:0]        flag;
  logic [NUM_PS*PS_W-1:0]   ps_load;
  logic [NUM_CH*CNT_W-1:0]  ch_load;
  logic [NUM_PS-1:0]        ps_tick;
  logic [NUM_CH-1:0]        ch_timeout;

  ct_regs #(
    .NUM_CH (NUM_CH),
    .NUM_PS (NUM_PS),
    .PS_W   (PS_W),
    .CNT_W  (CNT_W),
    .SW     (SEL_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .rdata   (bus_rdata),
    .timeout (ch_timeout),
    .run     (run),
    .ch_en   (ch_en),
    .ch_sel  (ch_sel),
    .int_en  (int_en),
    .flag    (flag),
    .ps_load (ps_load),
    .ch_load (ch_load)
  );

  for (genvar p = 0; p < NUM_PS; p++) begin : g_ps
    ct_prescaler #(.W(PS_W)) u_ps (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .load  (ps_load[p*PS_W +: PS_W]),
      .tick  (ps_tick[p])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ct_channel #(.W(CNT_W), .NPS(NUM_PS), .SW(SEL_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run && ch_en[c]),
      .sel     (ch_sel[c*SEL_W +: SEL_W]),
      .ticks   (ps_tick),
      .load    (ch_load[c*CNT_W +: CNT_W]),
      .timeout (ch_timeout[c])
    );
  end

  assign irq = flag & int_en;

endmodule

// File: rtl/ct_checker.sv
module ct_checker
  import ct_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int NUM_PS = 2,
  parameter int SEL_W  = 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_wr,
  input logic [4:0]              bus_addr,
  input logic [NUM_CH-1:0]       flag_wdata,
  input logic [NUM_CH-1:0]       irq,
  input logic                    run,
  input logic [NUM_CH-1:0]       ch_en,
  input logic [NUM_CH*SEL_W-1:0] ch_sel,
  input logic [NUM_CH-1:0]       int_en,
  input logic [NUM_CH-1:0]       flag,
  input logic [NUM_PS-1:0]       ps_tick,
  input logic [NUM_CH-1:0]       ch_timeout
);

  logic flag_wr;
  assign flag_wr = bus_wr && (bus_addr == A_FLAG);

  a_r6_halt_no_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (ch_timeout == '0));

  a_r6_halt_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_tick != '0) |-> run);

  a_r5_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_timeout & ~ch_en) == '0);

  a_r9_timeout_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_timeout != '0) |=> ((flag & $past(ch_timeout)) == $past(ch_timeout)));

  a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr |=> ((flag & $past(flag_wdata & ~ch_timeout)) == '0));

  a_r8_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> ((flag & $past(flag)) == $past(flag)));

  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~int_en) == '0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_src
    a_r4_tick_source: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_timeout[c] && (int'(ch_sel[c*SEL_W +: SEL_W]) < NUM_PS))
        |-> ps_tick[ch_sel[c*SEL_W +: SEL_W]]);
  end

endmodule

bind cascade_timer ct_checker #(
  .NUM_CH (NUM_CH),
  .NUM_PS (NUM_PS),
  .SEL_W  (SEL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .flag_wdata (bus_wdata[NUM_CH-1:0]),
  .irq        (irq),
  .run        (run),
  .ch_en      (ch_en),
  .ch_sel     (ch_sel),
  .int_en     (int_en),
  .flag       (flag),
  .ps_tick    (ps_tick),
  .ch_timeout (ch_timeout)
);

// File: tb/sim_cascade_timer.sv
`timescale 1ns/1ps
module sim_cascade_timer;

  localparam int A_CTRL = 0, A_CHEN = 1, A_SEL = 2, A_INTEN = 3, A_FLAG = 4;
  localparam int PSLD = 8, CHLD = 16;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [3:0]  irq;

  int total;
  int bad;
  int cyc;
  bit done;

  cascade_timer u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d (cycle %0d)", req, got, exp, cyc);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_addr  = 5'(a);
    bus_wdata = 16'(d);
    @(posedge clk);
    #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    bus_addr = 5'(a);
    #1;
    d = int'(bus_rdata);
  endtask

  task automatic wait_irq(input int ch, input int limit, output int at);
    at = -1;
    for (int k = 0; k < limit; k++) begin
      @(posedge clk);
      #1;
      if (irq[ch]) begin
        at = cyc;
        return;
      end
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=%0d cycles exp=completion", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int d, t0, at, n, m, c, p, per;
    int nv[4];
    int mv[3];
    int first[4];
    int expf[4];
    nv = '{0, 1, 2, 4};
    mv = '{0, 1, 3};
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    chk("R1 irq", int'(irq), 0);
    for (int a = 0; a < 5; a++) begin
      rd(a, d); chk("R1 reg", d, 0);
    end
    rd(PSLD + 1, d); chk("R1 psld", d, 0);
    rd(CHLD + 3, d); chk("R1 chld", d, 0);

    // R10: readback
    wr(PSLD + 1, 'hA5);   rd(PSLD + 1, d); chk("R10 psld", d, 'hA5);
    wr(PSLD + 0, 'h1FF);  rd(PSLD + 0, d); chk("R10 psld width", d, 'hFF);
    wr(CHLD + 3, 'hBEEF); rd(CHLD + 3, d); chk("R10 chld", d, 'hBEEF);
    wr(A_SEL, 'hFFFF);    rd(A_SEL, d);    chk("R10 sel", d, 'hF);
    wr(A_CHEN, 'h00F6);   rd(A_CHEN, d);   chk("R10 chen", d, 'h6);
    wr(A_INTEN, 'h0039);  rd(A_INTEN, d);  chk("R10 inten", d, 'h9);

    // R2 / R3 / R4 / R11 / R8 / R9 sweep, one channel at a time
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 3; j++) begin
        n = nv[i]; m = mv[j]; c = (i + j) % 4; p = j % 2;
        per = (n + 1) * (m + 1);
        wr(A_CTRL, 0);
        wr(A_FLAG, 'hFFFF);
        wr(PSLD + p, n);
        wr(PSLD + 1 - p, n + 3);
        wr(CHLD + c, m);
        wr(A_SEL, (p == 1) ? (1 << c) : 0);
        wr(A_CHEN, 1 << c);
        wr(A_INTEN, 1 << c);
        wr(A_CTRL, 'h80);
        t0 = cyc;
        wait_irq(c, 200, at);
        chk((m == 0) ? "R2 period" : "R3 first timeout", at - t0, per);
        wr(A_FLAG, 1 << c);
        rd(A_FLAG, d);
        if (per == 1) begin
          chk("R9 clear loses to timeout", (d >> c) & 1, 1);
        end else begin
          chk("R8 w1c clears", (d >> c) & 1, 0);
          wait_irq(c, 200, at);
          chk("R11 reload spacing", at - t0, 2 * per);
        end
      end
    end

    // R4 / R3: all channels together, mixed selects
    wr(A_CTRL, 0);
    wr(A_FLAG, 'hFFFF);
    wr(PSLD + 0, 2);
    wr(PSLD + 1, 4);
    wr(CHLD + 0, 1);
    wr(CHLD + 1, 2);
    wr(CHLD + 2, 0);
    wr(CHLD + 3, 3);
    wr(A_SEL, 'b0110);
    wr(A_CHEN, 'hF);
    wr(A_INTEN, 'hF);
    expf = '{6, 15, 5, 12};
    first = '{-1, -1, -1, -1};
    wr(A_CTRL, 'h80);
    t0 = cyc;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk);
      #1;
      for (int q = 0; q < 4; q++) begin
        if (irq[q] && first[q] < 0) first[q] = cyc - t0;
      end
    end
    for (int q = 0; q < 4; q++) chk("R4 mux period", first[q], expf[q]);

    // R5: disabled channel stays silent, enabling restarts from load
    wr(A_CTRL, 0);
    wr(A_FLAG, 'hFFFF);
    wr(PSLD + 0, 0);
    wr(CHLD + 2, 3);
    wr(A_SEL, 0);
    wr(A_CHEN, 0);
    wr(A_INTEN, 'h4);
    wr(A_CTRL, 'h80);
    repeat (30) @(posedge clk);
    rd(A_FLAG, d); chk("R5 disabled silent", d, 0);
    wr(A_CHEN, 'h4);
    t0 = cyc;
    wait_irq(2, 50, at);
    chk("R5 enable loads", at - t0, 4);

    // R6: only bit 7 runs the timer
    wr(A_CTRL, 0);
    wr(A_FLAG, 'hFFFF);
    for (int q = 0; q < 4; q++) wr(CHLD + q, 0);
    wr(A_CHEN, 'hF);
    wr(A_CTRL, 'h7F);
    repeat (20) @(posedge clk);
    rd(A_FLAG, d); chk("R6 other bits idle", d, 0);
    rd(A_CTRL, d); chk("R6 ctrl readback", d, 0);
    wr(A_CTRL, 'h80);
    repeat (3) @(posedge clk);
    wr(A_CTRL, 0);
    rd(A_FLAG, d); chk("R6 running sets flags", d, 'hF);

    // R7: interrupt gating, flags frozen while stopped
    wr(A_INTEN, 'b0101);
    @(negedge clk);
    chk("R7 irq gate", int'(irq), 'b0101);
    wr(A_INTEN, 0);
    @(negedge clk);
    chk("R7 irq off", int'(irq), 0);
    rd(A_FLAG, d); chk("R7 flag kept", d, 'hF);

    // R8: write-one-to-clear semantics
    wr(A_FLAG, 'h5); rd(A_FLAG, d); chk("R8 clear ones", d, 'hA);
    wr(A_FLAG, 0);   rd(A_FLAG, d); chk("R8 zero keeps", d, 'hA);
    rd(A_FLAG, d);
    wr(A_FLAG, d | 1);
    rd(A_FLAG, d); chk("R8 or-mask clears all", d, 0);

    // R6: stopped timer raises nothing
    repeat (20) @(posedge clk);
    rd(A_FLAG, d); chk("R6 halted", d, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule